// File: doc/BRIEF.md
# Edge-Latched Digital Input Interrupt Controller

This block watches eight digital inputs and turns selected transitions on them into one interrupt line. Every channel owns two sticky event bits, one set by a rising transition and one set by a falling transition. Each is armed by its own enable bit, so a channel can report rising edges only, falling edges only, or both. The interrupt output is high while any event bit is set. Software finds the source by reading two status words, one per edge direction. It then acknowledges a channel by reading that channel's clear address, which drops both of its event bits at once.

The interrupt output may be wired to an edge-sensitive input shared with other sources. A write to the status address therefore pulls the output low for a fixed number of clock cycles. A small state machine times this pulse. It has two states: `ST_IDLE`, where the output follows the event bits, and `ST_FORCE`, where the output is held low. A write taken in `ST_IDLE` moves it to `ST_FORCE` (transition *arm*). A write taken in `ST_FORCE` reloads the counter and stays in `ST_FORCE` (transition *rearm*). When the counter reaches zero with no write, it returns to `ST_IDLE` (transition *expire*). The synchronized input levels can also be read. All inputs pass through a two-flop synchronizer before edges are detected.

Top module: `dig_irq_ctrl`

## Requirements
- R1: A low-to-high change on `din[n]` while the rising enable bit n is 1 sets the rising event bit n. The bit is visible in the third clock edge after the input changes (two synchronizer flops plus the latch).
- R2: A high-to-low change on `din[n]` while the falling enable bit n is 1 sets the falling event bit n, with the same latency as R1.
- R3: The two directions are enabled independently per channel. A transition whose enable bit is 0 sets nothing. Clearing an enable bit does not remove an event bit that is already set.
- R4: `irq_out` is 1 whenever any event bit is set and no forced-low pulse is running. It stays 1 until every event bit is cleared.
- R5: A read of offset n (0 to 7) clears both event bits of channel n at that clock edge and leaves every other channel alone. The read returns 0.
- R6: Offset 8 holds the rising enables and offset 9 holds the falling enables. Both are writable and readable, with data bit n belonging to channel n.
- R7: Offset 0x0A reads the event OR in bit 0 (upper bits 0), regardless of any forced-low pulse. Offset 0x0B reads the rising event bits, 0x0C reads the falling event bits, and 0x0D reads the synchronized input levels. Bit n is channel n in each case, and these reads clear nothing.
- R8: A write to offset 0x0A moves the pulse machine from `ST_IDLE` to `ST_FORCE`. This holds `irq_out` low for exactly `PULSE_CYC` clock cycles after the write edge, after which the output follows the event bits again.
- R9: A write to 0x0A while in `ST_FORCE` restarts the full `PULSE_CYC` count from that write.
- R10: If a channel's edge sets an event bit in the same cycle that a read clears that channel, the set wins and the bit stays 1.
- R11: Reset clears all event bits, both enable registers and the pulse machine (`ST_IDLE`), so `irq_out` is 0.
- R12: Reads of offsets 0x0E and 0x0F return 0. Writes to any offset other than 8, 9 and 0x0A have no effect on enables, event bits or `irq_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Asynchronous digital inputs |
| addr | input | 4 | Register offset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the cycle `rd_en` is high |
| irq_out | output | 1 | Global interrupt |

## Verification
The input word is driven with random patterns under random per-channel enable combinations. In these patterns rising-only, falling-only, both and neither channels sit side by side, so a swapped direction or a missed enable shows up in the status words. Random single-channel clears are mixed in, which separates a clear of one channel from a clear of all channels. Directed cases cover the other corners. An edge is made to land on the clearing read's edge to test which of set and clear wins. The force-low pulse is counted cycle by cycle with one write and then with a second write inside the pulse, which shows whether the count restarts. Reads and writes of unused offsets are followed by status reads to show they changed nothing.

// File: rtl/dig_irq_pkg.sv
package dig_irq_pkg;

    localparam int unsigned ADDR_W   = 4;

    localparam logic [ADDR_W-1:0] OFS_RISE_EN  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_FALL_EN  = 4'h9;
    localparam logic [ADDR_W-1:0] OFS_GSTAT    = 4'hA;
    localparam logic [ADDR_W-1:0] OFS_RISE_EVT = 4'hB;
    localparam logic [ADDR_W-1:0] OFS_FALL_EVT = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_LEVEL    = 4'hD;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FORCE = 1'b1
    } pulse_state_t;

endpackage

// File: rtl/dig_irq_sync_edge.sv
module dig_irq_sync_edge #(
    parameter int unsigned NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] level,
    output logic [NCH-1:0] rise,
    output logic [NCH-1:0] fall
);
    logic [NCH-1:0] meta_q;
    logic [NCH-1:0] sync_q;
    logic [NCH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_edge
        assign rise[i] = sync_q[i] & ~prev_q[i];
        assign fall[i] = ~sync_q[i] & prev_q[i];

        // R3: a channel never reports both directions in one cycle
        p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({rise[i], fall[i]}));
    end

    assign level = sync_q;

endmodule

// File: rtl/dig_irq_latch_bank.sv
module dig_irq_latch_bank #(
    parameter int unsigned NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] rise,
    input  logic [NCH-1:0] fall,
    input  logic [NCH-1:0] rise_en,
    input  logic [NCH-1:0] fall_en,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] q_rise,
    output logic [NCH-1:0] q_fall,
    output logic           any_evt
);
    logic [NCH-1:0] set_r;
    logic [NCH-1:0] set_f;

    assign set_r = rise & rise_en;
    assign set_f = fall & fall_en;

    for (genvar i = 0; i < NCH; i++) begin : g_lat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_rise[i] <= 1'b0;
                q_fall[i] <= 1'b0;
            end else begin
                if (set_r[i])      q_rise[i] <= 1'b1;
                else if (clr[i])   q_rise[i] <= 1'b0;
                if (set_f[i])      q_fall[i] <= 1'b1;
                else if (clr[i])   q_fall[i] <= 1'b0;
            end
        end

        // R10: an accepted edge always leaves its bit set, even under clear
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (rise[i] && rise_en[i]) |=> q_rise[i]);
        // R5: a clear with no competing set empties both bits
        p_clear_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set_r[i] && !set_f[i]) |=> (!q_rise[i] && !q_fall[i]));
        // R3: a disabled rising edge never raises a cleared bit
        p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!q_rise[i] && !(rise[i] && rise_en[i])) |=> !q_rise[i]);
    end

    assign any_evt = (|q_rise) | (|q_fall);

endmodule

// File: rtl/dig_irq_force_fsm.sv
module dig_irq_force_fsm
    import dig_irq_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_req,
    output logic forcing
);
    localparam int unsigned CNT_W = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);

    pulse_state_t   state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (force_req) begin      // arm
                    state_d = ST_FORCE;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_FORCE: begin
                if (force_req) begin      // rearm
                    cnt_d = CNT_LOAD;
                end else if (cnt_q == '0) begin  // expire
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        forcing = (state_q == ST_FORCE);
    end

    // R9: any request reloads the full count
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        force_req |=> (state_q == ST_FORCE && cnt_q == CNT_LOAD));
    // R8: the pulse only ends after the count ran out
    p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(forcing) |-> ($past(cnt_q) == '0));

endmodule

// File: rtl/dig_irq_regs.sv
module dig_irq_regs
    import dig_irq_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [NCH-1:0]    wr_data,
    input  logic [NCH-1:0]    q_rise,
    input  logic [NCH-1:0]    q_fall,
    input  logic [NCH-1:0]    level,
    input  logic              any_evt,
    output logic [NCH-1:0]    rise_en,
    output logic [NCH-1:0]    fall_en,
    output logic [NCH-1:0]    clr,
    output logic              force_req,
    output logic [NCH-1:0]    rd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
        end else if (wr_en) begin
            if (addr == OFS_RISE_EN) rise_en <= wr_data;
            if (addr == OFS_FALL_EN) fall_en <= wr_data;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_clr
        assign clr[i] = rd_en && (addr == ADDR_W'(i));
    end

    assign force_req = wr_en && (addr == OFS_GSTAT);

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (addr)
                OFS_RISE_EN:  rd_data = rise_en;
                OFS_FALL_EN:  rd_data = fall_en;
                OFS_GSTAT:    rd_data = NCH'(any_evt);
                OFS_RISE_EVT: rd_data = q_rise;
                OFS_FALL_EVT: rd_data = q_fall;
                OFS_LEVEL:    rd_data = level;
                default:      rd_data = '0;
            endcase
        end
    end

    // R12: writes elsewhere leave the enables unchanged
    p_enable_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == OFS_RISE_EN || addr == OFS_FALL_EN))
        |=> ($stable(rise_en) && $stable(fall_en)));
    // R5: at most one channel is cleared per access
    p_single_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));

endmodule

// File: rtl/dig_irq_ctrl.sv
module dig_irq_ctrl
    import dig_irq_pkg::*;
#(
    parameter int unsigned NCH       = 8,
    parameter int unsigned PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [NCH-1:0]    wr_data,
    output logic [NCH-1:0]    rd_data,
    output logic              irq_out
);
    logic [NCH-1:0] level, rise, fall;
    logic [NCH-1:0] rise_en, fall_en, clr;
    logic [NCH-1:0] q_rise, q_fall;
    logic           any_evt, force_req, forcing;

    dig_irq_sync_edge #(.NCH(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(din),
        .level(level), .rise(rise), .fall(fall)
    );

    dig_irq_latch_bank #(.NCH(NCH)) u_lat (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .rise_en(rise_en), .fall_en(fall_en), .clr(clr),
        .q_rise(q_rise), .q_fall(q_fall), .any_evt(any_evt)
    );

    dig_irq_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .q_rise(q_rise),
        .q_fall(q_fall), .level(level), .any_evt(any_evt),
        .rise_en(rise_en), .fall_en(fall_en), .clr(clr),
        .force_req(force_req), .rd_data(rd_data)
    );

    dig_irq_force_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .force_req(force_req), .forcing(forcing)
    );

    assign irq_out = any_evt & ~forcing;

    // R4: without a read or a write, a raised interrupt stays raised
    p_irq_persist_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !rd_en && !wr_en) |=> irq_out);
    // R8: a status write always drops the line on the next cycle
    p_force_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_GSTAT) |=> !irq_out);

endmodule

// File: tb/sim_dig_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dig_irq_ctrl;
    localparam int NCH = 8;
    localparam int P   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] din = '0;
    logic [3:0] addr = '0;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic irq_out;

    int checks = 0, failures = 0;
    logic [7:0] e_er = '0, e_ef = '0, e_qr = '0, e_qf = '0, e_lvl = '0;

    always #2.5 clk = ~clk;

    dig_irq_ctrl #(.NCH(NCH), .PULSE_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic exp_irq();
        return (|e_qr) | (|e_qf);
    endfunction

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        @(posedge clk);
        #1 rd_en = 1'b0;
        if (a < 4'd8) begin
            e_qr[a[2:0]] = 1'b0;
            e_qf[a[2:0]] = 1'b0;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (a == 4'h8) e_er = d;
        if (a == 4'h9) e_ef = d;
    endtask

    // drive a new input word and let it settle through the pipeline
    task automatic drive(input logic [7:0] nv);
        @(negedge clk);
        e_qr |= nv & ~e_lvl & e_er;
        e_qf |= ~nv & e_lvl & e_ef;
        e_lvl = nv;
        din = nv;
        repeat (4) @(posedge clk);
    endtask

    task automatic chk_status(string tag);
        logic [7:0] v;
        rd(4'hB, v); chk({tag, " R1 rising status"}, v, e_qr);
        rd(4'hC, v); chk({tag, " R2 falling status"}, v, e_qf);
        rd(4'hD, v); chk({tag, " R7 level"}, v, e_lvl);
        rd(4'hA, v); chk({tag, " R7 gstat"}, v, {7'b0, exp_irq()});
        @(negedge clk);
        chk({tag, " R4 irq"}, {7'b0, irq_out}, {7'b0, exp_irq()});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        @(negedge clk);
        chk("R11 irq after reset", {7'b0, irq_out}, 8'h00);
        rd(4'h8, v); chk("R11 rise enable reset", v, 8'h00);
        rd(4'h9, v); chk("R11 fall enable reset", v, 8'h00);
        chk_status("R11");

        // R6 enable readback
        wr(4'h8, 8'hA5); rd(4'h8, v); chk("R6 rise enable", v, 8'hA5);
        wr(4'h9, 8'h3C); rd(4'h9, v); chk("R6 fall enable", v, 8'h3C);

        // R3 disabled edges ignored
        wr(4'h8, 8'h00); wr(4'h9, 8'h00);
        drive(8'hFF); drive(8'h00);
        chk_status("R3 disabled");

        // R1 rising only on ch0, R2 falling only on ch1, both on ch2
        wr(4'h8, 8'h05); wr(4'h9, 8'h06);
        drive(8'h07);
        chk_status("R1 rise");
        drive(8'h00);
        chk_status("R2 fall");

        // R3 clearing an enable keeps a set bit
        wr(4'h8, 8'h00);
        rd(4'hB, v); chk("R3 enable off keeps bit", v, 8'h05);

        // R5 clear of channel 2 only
        rd(4'h2, v); chk("R5 clear returns zero", v, 8'h00);
        chk_status("R5 clear ch2");
        rd(4'h0, v); rd(4'h1, v);
        chk_status("R4 all cleared");

        // R12 unused offsets and stray writes
        wr(4'h8, 8'h01); drive(8'h01);
        rd(4'hE, v); chk("R12 offset E zero", v, 8'h00);
        rd(4'hF, v); chk("R12 offset F zero", v, 8'h00);
        wr(4'hB, 8'hFF); wr(4'h0, 8'hFF); wr(4'hD, 8'h00);
        rd(4'h8, v); chk("R12 enable untouched", v, 8'h01);
        chk_status("R12 no side effect");

        // R8 forced-low pulse length
        @(negedge clk); addr = 4'hA; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            chk("R8 irq held low", {7'b0, irq_out}, 8'h00);
        end
        @(negedge clk);
        chk("R8 irq back high", {7'b0, irq_out}, 8'h01);

        // R9 restart during pulse
        @(negedge clk); addr = 4'hA; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
        @(negedge clk);
        addr = 4'hA; rd_en = 1'b1;
        #1 chk("R7 gstat ignores force", rd_data, 8'h01);
        @(posedge clk); #1 rd_en = 1'b0;
        @(negedge clk); addr = 4'hA; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            chk("R9 restarted low", {7'b0, irq_out}, 8'h00);
        end
        @(negedge clk);
        chk("R9 high after restart", {7'b0, irq_out}, 8'h01);
        rd(4'h0, v);

        // R10 set on the same edge as the clear
        wr(4'h9, 8'h08);
        @(negedge clk); din = 8'h09; e_lvl = 8'h09;
        @(posedge clk); @(posedge clk);
        @(negedge clk); din = 8'h01; e_lvl = 8'h01;
        @(posedge clk); @(posedge clk);
        @(negedge clk); addr = 4'h3; rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
        rd(4'hC, v); chk("R10 set wins over clear", v, 8'h08);
        e_qf = 8'h08;
        rd(4'h3, v);
        chk_status("R10 after");

        // random mix
        for (int n = 0; n < 60; n++) begin
            if (($urandom % 5) == 0) wr(4'h8, 8'($urandom));
            if (($urandom % 5) == 0) wr(4'h9, 8'($urandom));
            drive(8'($urandom));
            if (($urandom % 3) == 0) rd(4'($urandom % 8), v);
            chk_status("R1 R2 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule